// File: doc/BRIEF.md
# Register Readiness Scoreboard with Class Latencies

This block tells an issue queue, cycle by cycle, whether the value held in a renamed destination register can already be read. When an instruction issues, the block receives its class code, its destination tag, the execution cluster it runs in, and a flag saying whether it writes a register. It looks up the class latency and starts a per-tag down-counter. A consumer then asks about a tag. It supplies its own cluster and class, and the block answers ready or not ready for the current cycle.

Integer producers are seen one cycle later by consumers in the other cluster. Loads start on the hit latency. A miss notice that arrives while that count is still running parks the tag until a fill-return pulse names it. The fill-return pulse restarts the count with the configured second-level delay. A first-half conditional move can be consumed only by the matching second-half conditional move.

Each tag is held by one small state machine with four states.
- `S_READY`: the value is settled and readable from both clusters.
- `S_COUNT`: a fixed latency is running down.
- `S_HITWIN`: a load is running its hit latency and can still be turned into a miss.
- `S_FILLWAIT`: a missed load is waiting for its fill.

The transitions are as follows.
- Issue: any state goes to `S_COUNT` or `S_HITWIN`, with the count set to latency minus one.
- Expire: `S_COUNT` or `S_HITWIN` goes to `S_READY` when the count is zero.
- Tick: `S_COUNT` or `S_HITWIN` decrements a nonzero count.
- Miss: `S_HITWIN` goes to `S_FILLWAIT` while the count is nonzero.
- Fill: `S_FILLWAIT` goes to `S_COUNT`, with the count set to the fill delay minus one.
- Reset: every entry goes to `S_READY`.

Top module: `rdy_sb`

## Requirements
- R1: After synchronous reset, every tag reads ready for every consumer class and cluster.
- R2: A producer issued in cycle k reads ready from the same cluster first in cycle k+L and stays ready. Class codes and their L values are:
  - 0 integer ALU: 1
  - 1 address compute: 1
  - 2 cycle-counter read: 1
  - 3 integer-unit internal register read: 1
  - 4 conditional move first half: 1
  - 5 conditional move second half: 1
  - 6 miscellaneous integer: 3
  - 7 fetch- or memory-unit internal register read: 3
  - 8 integer multiply: 7
  - 9 integer load: 3
  - 10 float load: 4
- R3: For every producer class except code 10, a consumer whose cluster bit differs from the producer's first reads ready one cycle later than in R2. A code-10 producer adds no such cycle.
- R4: An issue with the write flag low, or with one of the non-producing classes, leaves the tag's readiness unchanged. The non-producing classes are 11 integer store, 12 float store, 13 miscellaneous memory, 14 branch and 15 internal register write.
- R5: A miss notice for a load tag in cycle m of its hit window (k < m < k+L) makes the tag not ready until a fill. A fill pulse in cycle f then makes it ready in cycle f+FILL_LAT, plus one cycle across clusters for integer loads.
- R6: A fill pulse for a tag that is not waiting for a fill has no effect.
- R7: While a tag's pending or settled producer is a first-half conditional move (code 4), only a query of class 5 may read it ready. Any other query class reads not ready.
- R8: When an issue and a fill name the same tag in the same cycle, the issue wins, and the new latency applies from that cycle.
- R9: A miss notice that arrives when the tag is already readable, or that names a non-load producer, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_class | input | 4 | Class code of the issuing instruction |
| issue_tag | input | TAGW | Destination tag of the issuing instruction |
| issue_cluster | input | 1 | Cluster of the producer |
| issue_writes | input | 1 | The instruction writes a register |
| miss_valid | input | 1 | Data-cache miss notice |
| miss_tag | input | TAGW | Tag of the missing load |
| fill_valid | input | 1 | Fill-return pulse |
| fill_tag | input | TAGW | Tag the fill belongs to |
| qry_tag | input | TAGW | Tag being asked about |
| qry_cluster | input | 1 | Cluster of the consumer |
| qry_class | input | 4 | Class code of the consumer |
| qry_ready | output | 1 | The queried tag is readable this cycle |

## Verification
The bench measures, for every producer class, the exact first cycle in which the tag turns ready, in both clusters. A design that is off by one in its counter, or that applies the cross-cluster cycle to float loads, shows up as an early or late edge. Miss tests place the notice early, late and on a non-load, and put fills on both waiting and non-waiting tags. A design that honours late misses or stray fills reports the wrong ready cycle.

A fill that collides with a new issue separates issue-wins from fill-wins by one cycle. Stores, branches and flag-low issues are sent against a busy tag, so an implementation that lets them write would clear or restart it. Conditional-move tests check that a first half stays unreadable to an ordinary consumer and readable to its partner.

// File: rtl/rdy_sb_pkg.sv
package rdy_sb_pkg;

    typedef enum logic [3:0] {
        C_IALU     = 4'd0,
        C_ADDR     = 4'd1,
        C_CYCRD    = 4'd2,
        C_IPRRD_E  = 4'd3,
        C_CMOV_A   = 4'd4,
        C_CMOV_B   = 4'd5,
        C_IMISC    = 4'd6,
        C_IPRRD_F  = 4'd7,
        C_IMUL     = 4'd8,
        C_ILOAD    = 4'd9,
        C_FLOAD    = 4'd10,
        C_ISTORE   = 4'd11,
        C_FSTORE   = 4'd12,
        C_MEMMISC  = 4'd13,
        C_BRANCH   = 4'd14,
        C_IPRWR    = 4'd15
    } iclass_e;

    typedef enum logic [1:0] {
        S_READY    = 2'd0,
        S_COUNT    = 2'd1,
        S_HITWIN   = 2'd2,
        S_FILLWAIT = 2'd3
    } ent_st_e;

    localparam int LATW = 3;

    typedef struct packed {
        logic            produces;
        logic            is_load;
        logic            xdly;
        logic            is_cm1;
        logic [LATW-1:0] lat;
    } cls_info_t;

endpackage

// File: rtl/rdy_sb_decode.sv
module rdy_sb_decode
    import rdy_sb_pkg::*;
(
    input  iclass_e   cls,
    output cls_info_t info
);
    always_comb begin
        info = '{produces: 1'b1, is_load: 1'b0, xdly: 1'b1, is_cm1: 1'b0, lat: LATW'(1)};
        unique case (cls)
            C_IALU, C_ADDR, C_CYCRD, C_IPRRD_E, C_CMOV_B: info.lat = LATW'(1);
            C_CMOV_A: begin
                info.lat    = LATW'(1);
                info.is_cm1 = 1'b1;
            end
            C_IMISC, C_IPRRD_F: info.lat = LATW'(3);
            C_IMUL: info.lat = LATW'(7);
            C_ILOAD: begin
                info.lat     = LATW'(3);
                info.is_load = 1'b1;
            end
            C_FLOAD: begin
                info.lat     = LATW'(4);
                info.is_load = 1'b1;
                info.xdly    = 1'b0;
            end
            C_ISTORE, C_FSTORE, C_MEMMISC, C_BRANCH, C_IPRWR: begin
                info.produces = 1'b0;
                info.xdly     = 1'b0;
            end
            default: info.produces = 1'b0;
        endcase
    end
endmodule

// File: rtl/rdy_sb_entry.sv
module rdy_sb_entry
    import rdy_sb_pkg::*;
#(
    parameter int CNTW     = 4,
    parameter int FILL_LAT = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set,
    input  logic [LATW-1:0] set_lat,
    input  logic            set_load,
    input  logic            set_xdly,
    input  logic            set_cm1,
    input  logic            set_cluster,
    input  logic            miss_hit,
    input  logic            fill_hit,
    output logic            rdy_near,
    output logic            rdy_far,
    output logic            cl,
    output logic            cm1
);
    localparam logic [CNTW-1:0] FILL_CNT = CNTW'(FILL_LAT - 1);

    ent_st_e         st, st_nx;
    logic [CNTW-1:0] cnt, cnt_nx;
    logic            xd, xd_nx, cl_nx, cm1_nx;

    // next-state logic
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        xd_nx  = xd;
        cl_nx  = cl;
        cm1_nx = cm1;
        if (set) begin
            st_nx  = set_load ? S_HITWIN : S_COUNT;
            cnt_nx = CNTW'(set_lat) - CNTW'(1);
            xd_nx  = set_xdly;
            cl_nx  = set_cluster;
            cm1_nx = set_cm1;
        end else begin
            unique case (st)
                S_READY: st_nx = S_READY;
                S_COUNT: begin
                    if (cnt == '0) st_nx  = S_READY;
                    else           cnt_nx = cnt - CNTW'(1);
                end
                S_HITWIN: begin
                    if (cnt == '0)    st_nx  = S_READY;
                    else if (miss_hit) st_nx = S_FILLWAIT;
                    else              cnt_nx = cnt - CNTW'(1);
                end
                S_FILLWAIT: begin
                    if (fill_hit) begin
                        st_nx  = S_COUNT;
                        cnt_nx = FILL_CNT;
                    end
                end
                default: st_nx = S_READY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_READY;
            cnt <= '0;
            xd  <= 1'b0;
            cl  <= 1'b0;
            cm1 <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            xd  <= xd_nx;
            cl  <= cl_nx;
            cm1 <= cm1_nx;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            S_READY:            rdy_near = 1'b1;
            S_COUNT, S_HITWIN:  rdy_near = (cnt == '0);
            S_FILLWAIT:         rdy_near = 1'b0;
            default:            rdy_near = 1'b0;
        endcase
        rdy_far = xd ? (st == S_READY) : rdy_near;
    end

    assert_fillwait_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (st == S_FILLWAIT && $past(st) != S_FILLWAIT) |-> $past(st) == S_HITWIN);

    assert_stray_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (st == S_READY && !set) |=> st == S_READY);

    assert_fillwait_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (st == S_FILLWAIT && !fill_hit && !set) |=> st == S_FILLWAIT);

    assert_countdown_R2: assert property (@(posedge clk) disable iff (rst)
        ((st == S_COUNT || st == S_HITWIN) && cnt != '0 && !set && !(st == S_HITWIN && miss_hit))
        |=> cnt == $past(cnt) - CNTW'(1));

    assert_issue_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set |=> ((st == S_COUNT || st == S_HITWIN) && cnt == CNTW'($past(set_lat)) - CNTW'(1)));

    assert_far_after_near_R3: assert property (@(posedge clk) disable iff (rst)
        rdy_far |-> rdy_near);
endmodule

// File: rtl/rdy_sb_select.sv
module rdy_sb_select #(
    parameter int TAGS = 16,
    parameter int TAGW = $clog2(TAGS)
) (
    input  logic [TAGS-1:0] near,
    input  logic [TAGS-1:0] far,
    input  logic [TAGS-1:0] cl,
    input  logic [TAGS-1:0] cm1,
    input  logic [TAGW-1:0] qry_tag,
    input  logic            qry_cluster,
    input  logic            qry_is_cmb,
    output logic            ready
);
    always_comb begin
        if (cm1[qry_tag] && !qry_is_cmb)
            ready = 1'b0;
        else if (qry_cluster == cl[qry_tag])
            ready = near[qry_tag];
        else
            ready = far[qry_tag];
    end
endmodule

// File: rtl/rdy_sb.sv
module rdy_sb
    import rdy_sb_pkg::*;
#(
    parameter int TAGS     = 16,
    parameter int CNTW     = 4,
    parameter int FILL_LAT = 6,
    localparam int TAGW    = $clog2(TAGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid,
    input  logic [3:0]      issue_class,
    input  logic [TAGW-1:0] issue_tag,
    input  logic            issue_cluster,
    input  logic            issue_writes,
    input  logic            miss_valid,
    input  logic [TAGW-1:0] miss_tag,
    input  logic            fill_valid,
    input  logic [TAGW-1:0] fill_tag,
    input  logic [TAGW-1:0] qry_tag,
    input  logic            qry_cluster,
    input  logic [3:0]      qry_class,
    output logic            qry_ready
);
    cls_info_t       info;
    logic            do_set;
    logic [TAGS-1:0] near, far, cl, cm1;

    rdy_sb_decode u_dec (
        .cls  (iclass_e'(issue_class)),
        .info (info)
    );

    assign do_set = issue_valid && issue_writes && info.produces;

    for (genvar t = 0; t < TAGS; t++) begin : g_ent
        rdy_sb_entry #(
            .CNTW     (CNTW),
            .FILL_LAT (FILL_LAT)
        ) u_ent (
            .clk         (clk),
            .rst         (rst),
            .set         (do_set && issue_tag == TAGW'(t)),
            .set_lat     (info.lat),
            .set_load    (info.is_load),
            .set_xdly    (info.xdly),
            .set_cm1     (info.is_cm1),
            .set_cluster (issue_cluster),
            .miss_hit    (miss_valid && miss_tag == TAGW'(t)),
            .fill_hit    (fill_valid && fill_tag == TAGW'(t)),
            .rdy_near    (near[t]),
            .rdy_far     (far[t]),
            .cl          (cl[t]),
            .cm1         (cm1[t])
        );
    end

    rdy_sb_select #(
        .TAGS (TAGS),
        .TAGW (TAGW)
    ) u_sel (
        .near        (near),
        .far         (far),
        .cl          (cl),
        .cm1         (cm1),
        .qry_tag     (qry_tag),
        .qry_cluster (qry_cluster),
        .qry_is_cmb  (qry_class == 4'(C_CMOV_B)),
        .ready       (qry_ready)
    );

    assert_cmov_pair_R7: assert property (@(posedge clk) disable iff (rst)
        (qry_ready && cm1[qry_tag]) |-> qry_class == 4'(C_CMOV_B));

    assert_nonprod_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !do_set && near == '1) |=> near == '1);
endmodule

// File: tb/rdy_sb_tb.sv
module rdy_sb_tb;
    localparam int TAGS = 16;
    localparam int TAGW = 4;
    localparam int FL   = 6;
    localparam int WIN  = 30;
    localparam int NEVER = 31;

    typedef struct packed {
        logic [3:0] cls;
        logic       wr;
        logic       pc;
        logic       cc;
        logic [3:0] qc;
        logic [4:0] miss;
        logic [4:0] fill;
        logic [4:0] exp;
    } vec_t;

    localparam int NV = 27;
    // cls wr pc cc qc miss fill exp  (exp = first ready cycle after issue)
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b1,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd1},   // R2 alu
        '{4'd0,  1'b1,1'b0,1'b1,4'd0, 5'd0,5'd0, 5'd2},   // R3 alu cross
        '{4'd1,  1'b1,1'b1,1'b1,4'd0, 5'd0,5'd0, 5'd1},   // R2 addr
        '{4'd2,  1'b1,1'b1,1'b0,4'd0, 5'd0,5'd0, 5'd2},   // R3 cycrd cross
        '{4'd3,  1'b1,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd1},   // R2 iprrd int
        '{4'd7,  1'b1,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd3},   // R2 iprrd other
        '{4'd7,  1'b1,1'b0,1'b1,4'd0, 5'd0,5'd0, 5'd4},   // R3
        '{4'd6,  1'b1,1'b1,1'b1,4'd0, 5'd0,5'd0, 5'd3},   // R2 imisc
        '{4'd8,  1'b1,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd7},   // R2 imul
        '{4'd8,  1'b1,1'b1,1'b0,4'd0, 5'd0,5'd0, 5'd8},   // R3 imul cross
        '{4'd9,  1'b1,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd3},   // R2 iload hit
        '{4'd9,  1'b1,1'b0,1'b1,4'd0, 5'd0,5'd0, 5'd4},   // R3 iload cross
        '{4'd10, 1'b1,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd4},   // R2 fload hit
        '{4'd10, 1'b1,1'b0,1'b1,4'd0, 5'd0,5'd0, 5'd4},   // R3 fload no extra
        '{4'd9,  1'b1,1'b0,1'b0,4'd0, 5'd1,5'd7, 5'd13},  // R5 iload miss
        '{4'd10, 1'b1,1'b1,1'b0,4'd0, 5'd2,5'd8, 5'd14},  // R5 fload miss cross
        '{4'd9,  1'b1,1'b0,1'b1,4'd0, 5'd2,5'd10,5'd17},  // R5 iload miss cross
        '{4'd9,  1'b1,1'b0,1'b0,4'd0, 5'd3,5'd0, 5'd3},   // R9 late miss
        '{4'd4,  1'b1,1'b0,1'b0,4'd5, 5'd0,5'd0, 5'd1},   // R7 cmov pair
        '{4'd4,  1'b1,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd31},  // R7 cmov other
        '{4'd5,  1'b1,1'b0,1'b1,4'd0, 5'd0,5'd0, 5'd2},   // R2 cmov second half
        '{4'd11, 1'b1,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd1},   // R4 store
        '{4'd0,  1'b0,1'b0,1'b0,4'd0, 5'd0,5'd0, 5'd1},   // R4 flag low
        '{4'd9,  1'b1,1'b0,1'b0,4'd0, 5'd1,5'd20,5'd26},  // R5 long wait
        '{4'd8,  1'b1,1'b0,1'b0,4'd0, 5'd0,5'd2, 5'd7},   // R6 stray fill
        '{4'd8,  1'b1,1'b0,1'b0,4'd0, 5'd2,5'd0, 5'd7},   // R9 miss on non-load
        '{4'd4,  1'b1,1'b0,1'b1,4'd5, 5'd0,5'd0, 5'd2}    // R7 pair cross
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            issue_valid = 1'b0;
    logic [3:0]      issue_class = '0;
    logic [TAGW-1:0] issue_tag = '0;
    logic            issue_cluster = 1'b0;
    logic            issue_writes = 1'b0;
    logic            miss_valid = 1'b0;
    logic [TAGW-1:0] miss_tag = '0;
    logic            fill_valid = 1'b0;
    logic [TAGW-1:0] fill_tag = '0;
    logic [TAGW-1:0] qry_tag = '0;
    logic            qry_cluster = 1'b0;
    logic [3:0]      qry_class = '0;
    logic            qry_ready;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rdy_sb #(.TAGS(TAGS), .CNTW(4), .FILL_LAT(FL)) u_dut (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_class(issue_class), .issue_tag(issue_tag),
        .issue_cluster(issue_cluster), .issue_writes(issue_writes),
        .miss_valid(miss_valid), .miss_tag(miss_tag),
        .fill_valid(fill_valid), .fill_tag(fill_tag),
        .qry_tag(qry_tag), .qry_cluster(qry_cluster), .qry_class(qry_class),
        .qry_ready(qry_ready)
    );

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: first ready cycle %0d, expected %0d", req, act, expv);
        end
    endtask

    // observe cycles from..WIN; returns first ready cycle (NEVER if none, -1 if it dropped)
    task automatic observe(input int from, input int tg, input int mis, input int fil,
                           output int first);
        first = NEVER;
        for (int j = from; j <= WIN; j++) begin
            @(negedge clk);
            issue_valid = 1'b0;
            miss_valid  = (j == mis);
            miss_tag    = TAGW'(tg);
            fill_valid  = (j == fil);
            fill_tag    = TAGW'(tg);
            #1;
            if (qry_ready) begin
                if (first == NEVER) first = j;
            end else if (first != NEVER) begin
                first = -1;
            end
        end
        @(negedge clk);
        miss_valid = 1'b0;
        fill_valid = 1'b0;
    endtask

    task automatic issue(input int cls, input bit wr, input bit pc, input int tg);
        issue_valid   = 1'b1;
        issue_class   = 4'(cls);
        issue_writes  = wr;
        issue_cluster = pc;
        issue_tag     = TAGW'(tg);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int first;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every tag ready after reset, both clusters
        bad = 0;
        for (int t = 0; t < TAGS; t++) begin
            for (int c = 0; c < 2; c++) begin
                qry_tag = TAGW'(t); qry_cluster = c[0]; qry_class = 4'd0;
                #1;
                if (!qry_ready) bad++;
            end
        end
        n_chk++;
        if (bad != 0) begin
            n_bad++;
            $display("FAIL R1: %0d tag/cluster pairs not ready, expected 0", bad);
        end

        // table walk (R2, R3, R4, R5, R6, R7, R9)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            qry_tag     = TAGW'(i % TAGS);
            qry_cluster = VECS[i].cc;
            qry_class   = VECS[i].qc;
            issue(int'(VECS[i].cls), VECS[i].wr, VECS[i].pc, i % TAGS);
            observe(1, i % TAGS, int'(VECS[i].miss), int'(VECS[i].fill), first);
            check($sformatf("vector %0d (R2/R3/R4/R5/R6/R7/R9)", i), first, int'(VECS[i].exp));
        end

        // R4: non-producing issues against a busy tag leave it counting
        @(negedge clk);
        qry_tag = TAGW'(3); qry_cluster = 1'b0; qry_class = 4'd0;
        issue(8, 1'b1, 1'b0, 3);
        @(negedge clk);
        issue(11, 1'b1, 1'b0, 3);
        @(negedge clk);
        issue(0, 1'b0, 1'b0, 3);
        observe(3, 3, 0, 0, first);
        check("R4 busy tag", first, 7);

        // R8: issue and fill on the same tag in the same cycle
        @(negedge clk);
        qry_tag = TAGW'(6); qry_cluster = 1'b0; qry_class = 4'd0;
        issue(9, 1'b1, 1'b0, 6);
        @(negedge clk);
        issue_valid = 1'b0;
        miss_valid = 1'b1; miss_tag = TAGW'(6);
        @(negedge clk);
        miss_valid = 1'b0;
        @(negedge clk);
        issue(8, 1'b1, 1'b0, 6);
        fill_valid = 1'b1; fill_tag = TAGW'(6);
        observe(4, 6, 0, 0, first);
        check("R8 issue over fill", first, 10);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule